// File: doc/BRIEF.md
# Transmit Level and Line-Driver Protection Controller

This block sets the digital attenuation of the transmit path and guards the line driver against over-current and over-temperature. A host writes a 5-bit target level. The block reloads that level at the start of every transmission. While the transmission runs and the over-current comparator stays asserted, it backs the level off one step at each adjustment tick. The tick period is programmable, so the host can choose how fast the back-off runs.

Four temperature comparators form a thermometer code. The block derives a 2-bit temperature zone from them and disables the line driver when the hottest threshold trips. It turns the driver back on only after the temperature falls below the third threshold, which gives the shutdown hysteresis. A further output tells the external pad to pull the current-limit resistor selector low in FSK mode and to release it in PSK mode. All comparator inputs come from the analog side and are resynchronised inside the block.

Top module: `txpa_ctrl`

## Requirements
- R1: The level output is 5 bits and covers codes 0 to 31. The attenuation in dB equals the code minus 31, so 31 is full scale. While `tx_en` is low, the output follows `target_gain` one cycle later.
- R2: On the first clock edge with `tx_en` high after it was low, the level output loads `target_gain`.
- R3: While a transmission runs and the synchronised over-current flag is high, each adjustment tick lowers the level by exactly one code.
- R4: Adjustment ticks occur every `tick_div`+1 cycles. The tick counter restarts at transmission start, so the first tick falls on the edge that comes `tick_div`+1 edges after the start edge.
- R5: The level never goes below 0. Once it reaches 0 it stays at 0 while over-current persists.
- R6: While the synchronised over-current flag is low and the target is unchanged, the level stays constant during a transmission.
- R7: During a transmission the level never rises above the target. If the target drops below the current level, the level moves to the new target on the next edge. If the target rises, the level does not follow it.
- R8: When comparator bit 3 (above the fourth threshold) reads high, `pa_en` goes low.
- R9: After a shutdown, `pa_en` returns high only once comparator bit 2 (above the third threshold) reads low. It stays low while bit 2 is high and bit 3 is low.
- R10: `zone` is the zone number minus one. It is 0 when no threshold is exceeded, 1 above threshold 1 only, 2 above threshold 2, and 3 above threshold 3. Input bit k means above threshold k+1.
- R11: `rlim_pull` is 1 (drive the selector low) one cycle after `mod_psk` is 0 (FSK). It is 0 (selector released) one cycle after `mod_psk` is 1 (PSK).
- R12: Each comparator input passes through two synchroniser flops. A change reaches `pa_en` and `zone` on the third clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_gain | input | 5 | Host-programmed transmit level |
| tx_en | input | 1 | Transmission active |
| mod_psk | input | 1 | 1 selects PSK, 0 selects FSK |
| oc_raw | input | 1 | Asynchronous over-current comparator result |
| temp_raw | input | 4 | Asynchronous temperature comparators; bit k means above threshold k+1 |
| tick_div | input | TICK_W | Adjustment tick period minus one, in cycles |
| gain_out | output | 5 | Effective transmit level |
| pa_en | output | 1 | Line-driver enable |
| rlim_pull | output | 1 | 1 drives the current-limit selector low, 0 releases it |
| zone | output | 2 | Temperature zone minus one |

## Verification
The hardest case to reach is a level step landing on an exact tick edge. That requires the synchronised over-current flag to be stable before the transmission starts, and the tick phase to be known. The stimulus raises the comparator several cycles ahead, then starts the transmission. Because the counter restarts at that edge, the bench can predict the edge of each step by counting, and it checks the cycle just before each step as well. The thermal hysteresis band is entered by stepping the thermometer code down through the third threshold after a shutdown.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
    localparam int GAIN_W   = 5;
    localparam int TEMP_N   = 4;
    localparam int ZONE_W   = 2;

    typedef logic [GAIN_W-1:0] gain_t;

    typedef enum logic [ZONE_W-1:0] {
        ZONE_COOL = 2'd0,
        ZONE_WARM = 2'd1,
        ZONE_HOT  = 2'd2,
        ZONE_CRIT = 2'd3
    } zone_e;

    localparam int IDX_TH3 = 2;
    localparam int IDX_TH4 = 3;
endpackage

// File: rtl/txpa_sync.sv
module txpa_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_st;

    sync_st s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stage[i] = s_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.stage[STAGES-1];
endmodule

// File: rtl/txpa_tick.sv
module txpa_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st;

    tick_st t_d, t_q;
    logic   at_limit;

    always_comb begin
        t_d      = t_q;
        at_limit = (t_q.cnt >= limit);
        if (!run || restart) begin
            t_d.cnt = '0;
        end else if (at_limit) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tick = run && !restart && at_limit;
endmodule

// File: rtl/txpa_gain.sv
module txpa_gain
    import txpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_en,
    input  gain_t target,
    input  logic  oc,
    input  logic  tick,
    output logic  tx_start,
    output gain_t gain
);
    typedef struct packed {
        logic  tx;
        gain_t lvl;
    } gain_st;

    gain_st g_d, g_q;

    always_comb begin
        g_d    = g_q;
        g_d.tx = tx_en;
        if (!tx_en || !g_q.tx) begin
            g_d.lvl = target;
        end else if (g_q.lvl > target) begin
            g_d.lvl = target;
        end else if (tick && oc && (g_q.lvl != '0)) begin
            g_d.lvl = g_q.lvl - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign tx_start = tx_en && !g_q.tx;
    assign gain     = g_q.lvl;
endmodule

// File: rtl/txpa_thermal.sv
module txpa_thermal
    import txpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_N-1:0] above,
    output logic              pa_en,
    output zone_e             zone
);
    typedef struct packed {
        logic  shut;
        zone_e zn;
    } therm_st;

    therm_st h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (above[IDX_TH4]) begin
            h_d.shut = 1'b1;
        end else if (!above[IDX_TH3]) begin
            h_d.shut = 1'b0;
        end
        if (above[2])      h_d.zn = ZONE_CRIT;
        else if (above[1]) h_d.zn = ZONE_HOT;
        else if (above[0]) h_d.zn = ZONE_WARM;
        else               h_d.zn = ZONE_COOL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{shut: 1'b0, zn: ZONE_COOL};
        else        h_q <= h_d;
    end

    assign pa_en = !h_q.shut;
    assign zone  = h_q.zn;
endmodule

// File: rtl/txpa_ctrl.sv
module txpa_ctrl
    import txpa_pkg::*;
#(
    parameter int TICK_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        target_gain,
    input  logic              tx_en,
    input  logic              mod_psk,
    input  logic              oc_raw,
    input  logic [3:0]        temp_raw,
    input  logic [TICK_W-1:0] tick_div,
    output logic [4:0]        gain_out,
    output logic              pa_en,
    output logic              rlim_pull,
    output logic [1:0]        zone
);
    localparam int CMP_N = TEMP_N + 1;

    typedef struct packed {
        logic pull;
    } pad_st;

    logic [CMP_N-1:0]  cmp_s;
    logic              oc_s;
    logic [TEMP_N-1:0] temp_s;
    logic              tick;
    logic              tx_start;
    gain_t             lvl;
    zone_e             zn;
    pad_st             p_d, p_q;

    txpa_sync #(.WIDTH(CMP_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({oc_raw, temp_raw}),
        .dout (cmp_s)
    );

    assign oc_s   = cmp_s[CMP_N-1];
    assign temp_s = cmp_s[TEMP_N-1:0];

    txpa_tick #(.CNT_W(TICK_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tx_en),
        .restart(tx_start),
        .limit  (tick_div),
        .tick   (tick)
    );

    txpa_gain u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .target  (target_gain),
        .oc      (oc_s),
        .tick    (tick),
        .tx_start(tx_start),
        .gain    (lvl)
    );

    txpa_thermal u_therm (
        .clk  (clk),
        .rst_n(rst_n),
        .above(temp_s),
        .pa_en(pa_en),
        .zone (zn)
    );

    always_comb begin
        p_d      = p_q;
        p_d.pull = !mod_psk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign gain_out  = lvl;
    assign zone      = zn;
    assign rlim_pull = p_q.pull;
endmodule

// File: rtl/txpa_ctrl_chk.sv
module txpa_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] target_gain,
    input logic       tx_en,
    input logic       mod_psk,
    input logic [4:0] gain_out,
    input logic       pa_en,
    input logic       rlim_pull,
    input logic [1:0] zone,
    input logic       oc_s,
    input logic [3:0] temp_s
);
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $stable(target_gain) && ($past(gain_out) <= target_gain))
        |-> (gain_out == $past(gain_out) || gain_out == $past(gain_out) - 5'd1));

    assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $past(gain_out) == 5'd0) |-> (gain_out == 5'd0));

    assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $stable(target_gain)) |-> (gain_out <= target_gain));

    assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        temp_s[3] |=> !pa_en);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_s[2] && !temp_s[3] |=> pa_en);

    assert_hold_band_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_s[2] && !temp_s[3] && !pa_en) |=> !pa_en);

    assert_zone_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        temp_s[2] |=> (zone == 2'd3));

    assert_zone_cool_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_s == 4'b0000) |=> (zone == 2'd0));

    assert_pad_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mod_psk |=> !rlim_pull);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && !$past(oc_s) && $stable(target_gain) && ($past(gain_out) <= target_gain))
        |-> $stable(gain_out));
endmodule

bind txpa_ctrl txpa_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .target_gain(target_gain),
    .tx_en      (tx_en),
    .mod_psk    (mod_psk),
    .gain_out   (gain_out),
    .pa_en      (pa_en),
    .rlim_pull  (rlim_pull),
    .zone       (zone),
    .oc_s       (oc_s),
    .temp_s     (temp_s)
);

// File: tb/sim_txpa_ctrl.sv
`timescale 1ns/1ps
module sim_txpa_ctrl;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    target_gain = '0;
    logic          tx_en = 1'b0;
    logic          mod_psk = 1'b1;
    logic          oc_raw = 1'b0;
    logic [3:0]    temp_raw = '0;
    logic [TW-1:0] tick_div = '0;
    logic [4:0]    gain_out;
    logic          pa_en;
    logic          rlim_pull;
    logic [1:0]    zone;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txpa_ctrl #(.TICK_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .target_gain(target_gain), .tx_en(tx_en),
        .mod_psk(mod_psk), .oc_raw(oc_raw), .temp_raw(temp_raw), .tick_div(tick_div),
        .gain_out(gain_out), .pa_en(pa_en), .rlim_pull(rlim_pull), .zone(zone)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        check(gain_out == 5'd0, "R1 reset level", gain_out, 0);
        check(pa_en == 1'b1, "R8 reset pa_en", pa_en, 1);
        check(zone == 2'd0, "R10 reset zone", zone, 0);
        check(rlim_pull == 1'b0, "R11 reset pad", rlim_pull, 0);
    endtask

    task automatic t_idle_follow;
        target_gain = 5'd17; step(1);
        check(gain_out == 5'd17, "R1 idle follow 17", gain_out, 17);
        target_gain = 5'd31; step(1);
        check(gain_out == 5'd31, "R1 idle follow 31", gain_out, 31);
    endtask

    task automatic t_backoff;
        tick_div = 16'd3; oc_raw = 1'b1; target_gain = 5'd20; step(4);
        tx_en = 1'b1; step(1);
        check(gain_out == 5'd20, "R2 load at start", gain_out, 20);
        step(3);
        check(gain_out == 5'd20, "R4 no step before first tick", gain_out, 20);
        step(1);
        check(gain_out == 5'd19, "R3 first step", gain_out, 19);
        step(3);
        check(gain_out == 5'd19, "R4 hold between ticks", gain_out, 19);
        step(1);
        check(gain_out == 5'd18, "R3 second step", gain_out, 18);
        oc_raw = 1'b0; step(4);
        begin
            logic [4:0] held;
            held = gain_out;
            step(24);
            check(gain_out == held, "R6 stable without over-current", gain_out, held);
        end
        tx_en = 1'b0; step(1);
    endtask

    task automatic t_reload;
        target_gain = 5'd9; step(2);
        tx_en = 1'b1; step(1);
        check(gain_out == 5'd9, "R2 reload new target", gain_out, 9);
        tx_en = 1'b0; step(1);
    endtask

    task automatic t_floor;
        tick_div = 16'd0; target_gain = 5'd2; oc_raw = 1'b1; step(4);
        tx_en = 1'b1; step(1);
        check(gain_out == 5'd2, "R2 load 2", gain_out, 2);
        step(1);
        check(gain_out == 5'd1, "R4 every-cycle tick", gain_out, 1);
        step(20);
        check(gain_out == 5'd0, "R5 floor at zero", gain_out, 0);
        tx_en = 1'b0; oc_raw = 1'b0; step(4);
    endtask

    task automatic t_cap;
        target_gain = 5'd25; step(1);
        tx_en = 1'b1; step(2);
        check(gain_out == 5'd25, "R7 start level", gain_out, 25);
        target_gain = 5'd10; step(1);
        check(gain_out == 5'd10, "R7 clamp to lower target", gain_out, 10);
        target_gain = 5'd30; step(5);
        check(gain_out == 5'd10, "R7 no rise to higher target", gain_out, 10);
        tx_en = 1'b0; step(1);
    endtask

    task automatic t_zones;
        temp_raw = 4'b0001; step(2);
        check(zone == 2'd0, "R12 zone not before third edge", zone, 0);
        step(1);
        check(zone == 2'd1, "R10 zone warm", zone, 1);
        temp_raw = 4'b0011; step(3);
        check(zone == 2'd2, "R10 zone hot", zone, 2);
        temp_raw = 4'b0111; step(3);
        check(zone == 2'd3, "R10 zone top", zone, 3);
        check(pa_en == 1'b1, "R8 enabled below fourth", pa_en, 1);
    endtask

    task automatic t_thermal;
        temp_raw = 4'b1111; step(2);
        check(pa_en == 1'b1, "R12 shutdown not before third edge", pa_en, 1);
        step(1);
        check(pa_en == 1'b0, "R8 shutdown", pa_en, 0);
        temp_raw = 4'b0111; step(12);
        check(pa_en == 1'b0, "R9 held in band", pa_en, 0);
        temp_raw = 4'b0011; step(2);
        check(pa_en == 1'b0, "R12 release not before third edge", pa_en, 0);
        step(1);
        check(pa_en == 1'b1, "R9 released below third", pa_en, 1);
        check(zone == 2'd2, "R10 zone after cooling", zone, 2);
        temp_raw = 4'b0000; step(3);
        check(zone == 2'd0, "R10 zone cool", zone, 0);
    endtask

    task automatic t_pad;
        mod_psk = 1'b0; step(1);
        check(rlim_pull == 1'b1, "R11 FSK drives low", rlim_pull, 1);
        mod_psk = 1'b1; step(1);
        check(rlim_pull == 1'b0, "R11 PSK releases", rlim_pull, 0);
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1; step(1);
        t_idle_follow();
        t_backoff();
        t_reload();
        t_floor();
        t_cap();
        t_zones();
        t_thermal();
        t_pad();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule